// File: doc/BRIEF.md
# Luma Difference Energy Calculator

This block sits in front of a seam search and produces one energy value for each pixel of the overlap region shared by two registered images. Each image delivers RGB pixels on its own valid/ready stream, row by row, with `W` pixels per row and `H` rows per frame. Every accepted pixel is turned into an 8-bit luma with a multiply-and-shift formula, with no divider. The luma is then stored in one of two row banks that belong to that image.

Once the same row is complete in both images, a single read sequencer sweeps that row out of the two images' banks in lockstep. For each column it emits the absolute luma difference together with its row and column position, a row-start marker and a frame-end marker. Each image's write side flips between its two banks every time it finishes a row. So an image may run up to two rows ahead of the output before its ready input drops.

Top module: `seam_energy_calc`

## Requirements
- R1: Luma of a pixel is floor((306·R + 601·G + 117·B) / 1024) on 8-bit channels, so full white gives 255 and black gives 0.
- R2: `en_value` equals |luma(left) − luma(right)| for the two pixels at the same row and column, whichever image is brighter.
- R3: Energies come out in row-major order; `en_col` counts 0..W−1 with no gap inside a row, and `en_row` counts 0..H−1.
- R4: `en_sol` is high exactly on the output beat whose `en_col` is 0.
- R5: `en_eof` is high exactly on the beat with `en_row` = H−1 and `en_col` = W−1, and the next beat restarts at row 0.
- R6: No energy of a row appears before both images have delivered that whole row.
- R7: An image's ready input is low exactly when that image holds two complete rows that have not yet been fully output. It rises on the cycle in which the last energy of the older row appears.
- R8: A pixel is taken only on a cycle where valid and ready are both high; a pixel held while ready is low is neither lost nor taken twice.
- R9: While reset is held, `en_valid`, `en_sol` and `en_eof` are low and both ready inputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lt_valid | input | 1 | Left-image pixel present |
| lt_red | input | 8 | Left-image red channel |
| lt_grn | input | 8 | Left-image green channel |
| lt_blu | input | 8 | Left-image blue channel |
| lt_ready | output | 1 | Left image may deliver a pixel |
| rt_valid | input | 1 | Right-image pixel present |
| rt_red | input | 8 | Right-image red channel |
| rt_grn | input | 8 | Right-image green channel |
| rt_blu | input | 8 | Right-image blue channel |
| rt_ready | output | 1 | Right image may deliver a pixel |
| en_valid | output | 1 | Energy beat present |
| en_value | output | 8 | Absolute luma difference |
| en_row | output | $clog2(H) | Row of this energy |
| en_col | output | $clog2(W) | Column of this energy |
| en_sol | output | 1 | First column of a row |
| en_eof | output | 1 | Last pixel of the frame |

## Verification
The assertions assume that each image's stream obeys the handshake: a pixel counts only when valid meets ready, and the two images send rows in the same order from the same frame start. There is no output-side stall, so the properties treat an output row as an unbroken burst of `W` beats. The stimulus holds each pixel stable until it is taken. It drives both images from their frame start together, and it switches between lockstep, left-ahead, right-ahead and random gaps, so the two-row lead and the ready drop actually occur.

// File: rtl/seam_energy_calc.sv
module seam_energy_calc #(
  parameter int W = 512,
  parameter int H = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lt_valid,
  input  logic [7:0]             lt_red,
  input  logic [7:0]             lt_grn,
  input  logic [7:0]             lt_blu,
  output logic                   lt_ready,
  input  logic                   rt_valid,
  input  logic [7:0]             rt_red,
  input  logic [7:0]             rt_grn,
  input  logic [7:0]             rt_blu,
  output logic                   rt_ready,
  output logic                   en_valid,
  output logic [7:0]             en_value,
  output logic [$clog2(H)-1:0]   en_row,
  output logic [$clog2(W)-1:0]   en_col,
  output logic                   en_sol,
  output logic                   en_eof
);
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(H);
  localparam logic [CW-1:0] COL_LAST = CW'(W - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(H - 1);

  function automatic logic [7:0] to_luma(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    logic [17:0] acc;
    acc = 18'(306) * 18'(r) + 18'(601) * 18'(g) + 18'(117) * 18'(b);
    return acc[17:10];
  endfunction

  logic [1:0]    in_v;
  logic [1:0]    in_rdy;
  logic [7:0]    y_in      [2];
  logic [7:0]    rd_y      [2];
  logic [1:0]    bank_full [2];

  logic          rbank;
  logic [CW-1:0] rcol;
  logic [RW-1:0] rrow;
  logic          rd_go;
  logic          rd_last;

  assign in_v     = {rt_valid, lt_valid};
  assign y_in[0]  = to_luma(lt_red, lt_grn, lt_blu);
  assign y_in[1]  = to_luma(rt_red, rt_grn, rt_blu);
  assign lt_ready = in_rdy[0];
  assign rt_ready = in_rdy[1];

  assign rd_go   = bank_full[0][rbank] & bank_full[1][rbank];
  assign rd_last = rd_go & (rcol == COL_LAST);

  for (genvar g = 0; g < 2; g++) begin : side
    logic [CW-1:0] wcol;
    logic          wsel;
    logic [1:0]    full;
    logic [7:0]    mem [2][W];
    logic          take;

    assign in_rdy[g]    = ~full[wsel];
    assign take         = in_v[g] & in_rdy[g];
    assign bank_full[g] = full;
    assign rd_y[g]      = mem[rbank][rcol];

    always_ff @(posedge clk) begin
      if (take) mem[wsel][wcol] <= y_in[g];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wcol <= '0;
        wsel <= 1'b0;
        full <= 2'b00;
      end else begin
        if (take) begin
          if (wcol == COL_LAST) begin
            wcol       <= '0;
            wsel       <= ~wsel;
            full[wsel] <= 1'b1;
          end else begin
            wcol <= wcol + 1'b1;
          end
        end
        if (rd_last) full[rbank] <= 1'b0;
      end
    end
  end

  logic [7:0] d_lr, d_rl;
  logic       l_ge;
  assign d_lr = rd_y[0] - rd_y[1];
  assign d_rl = rd_y[1] - rd_y[0];
  assign l_ge = rd_y[0] >= rd_y[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbank <= 1'b0;
      rcol  <= '0;
      rrow  <= '0;
    end else if (rd_go) begin
      if (rd_last) begin
        rcol  <= '0;
        rbank <= ~rbank;
        rrow  <= (rrow == ROW_LAST) ? '0 : rrow + 1'b1;
      end else begin
        rcol <= rcol + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_valid <= 1'b0;
      en_value <= '0;
      en_row   <= '0;
      en_col   <= '0;
      en_sol   <= 1'b0;
      en_eof   <= 1'b0;
    end else begin
      en_valid <= rd_go;
      en_value <= l_ge ? d_lr : d_rl;
      en_row   <= rrow;
      en_col   <= rcol;
      en_sol   <= rd_go & (rcol == '0);
      en_eof   <= rd_last & (rrow == ROW_LAST);
    end
  end
endmodule

module seam_energy_calc_chk #(
  parameter int W = 512,
  parameter int H = 512
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lt_ready,
  input logic                 rt_ready,
  input logic                 en_valid,
  input logic [$clog2(H)-1:0] en_row,
  input logic [$clog2(W)-1:0] en_col,
  input logic                 en_sol,
  input logic                 en_eof
);
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(H);

  p_row_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_valid && en_col != CW'(W - 1)) |=> (en_valid && en_col == $past(en_col) + 1'b1));

  p_sol_col0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_sol |-> (en_valid && en_col == '0));

  p_eof_corner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_eof |-> (en_valid && en_col == CW'(W - 1) && en_row == RW'(H - 1)));

  p_corner_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_valid && en_col == CW'(W - 1) && en_row == RW'(H - 1)) |-> en_eof);

  p_lt_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lt_ready) |-> (en_valid && en_col == CW'(W - 1)));

  p_rt_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rt_ready) |-> (en_valid && en_col == CW'(W - 1)));
endmodule

bind seam_energy_calc seam_energy_calc_chk #(.W(W), .H(H)) u_chk (
  .clk(clk), .rst_n(rst_n), .lt_ready(lt_ready), .rt_ready(rt_ready),
  .en_valid(en_valid), .en_row(en_row), .en_col(en_col),
  .en_sol(en_sol), .en_eof(en_eof)
);

// File: tb/seam_energy_calc_test.sv
module seam_energy_calc_test;
  localparam int W  = 8;
  localparam int H  = 4;
  localparam int FR = 4;
  localparam int N  = W * H * FR;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       lt_valid, rt_valid;
  logic [7:0] lt_red, lt_grn, lt_blu, rt_red, rt_grn, rt_blu;
  logic       lt_ready, rt_ready;
  logic       en_valid, en_sol, en_eof;
  logic [7:0] en_value;
  logic [$clog2(H)-1:0] en_row;
  logic [$clog2(W)-1:0] en_col;

  seam_energy_calc #(.W(W), .H(H)) uut (
    .clk(clk), .rst_n(rst_n),
    .lt_valid(lt_valid), .lt_red(lt_red), .lt_grn(lt_grn), .lt_blu(lt_blu), .lt_ready(lt_ready),
    .rt_valid(rt_valid), .rt_red(rt_red), .rt_grn(rt_grn), .rt_blu(rt_blu), .rt_ready(rt_ready),
    .en_valid(en_valid), .en_value(en_value), .en_row(en_row), .en_col(en_col),
    .en_sol(en_sol), .en_eof(en_eof)
  );

  int total = 0, bad = 0;
  int lq[$], rq[$];
  int lk = 0, rk = 0, out_n = 0, cyc = 0;
  bit lrdy_p, rrdy_p;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int luma(input int r, input int g, input int b);
    return (306 * r + 601 * g + 117 * b) >> 10;
  endfunction

  task automatic pick(input int side, input int k, output logic [7:0] r, output logic [7:0] g, output logic [7:0] b);
    case (k % 7)
      0: begin r = side ? 8'd0 : 8'd255; g = r; b = r; end
      1: begin r = side ? 8'd255 : 8'd0; g = r; b = r; end
      2: begin r = 8'(k * 37); g = 8'(k * 11); b = 8'(k * 5); end
      default: begin r = 8'($urandom); g = 8'($urandom); b = 8'($urandom); end
    endcase
  endtask

  function automatic bit want(input int side, input int k);
    int f;
    f = (k / (W * H)) % 4;
    case (f)
      0: return 1'b1;
      1: return side ? (cyc % 3 == 0) : 1'b1;
      2: return side ? 1'b1 : (cyc % 4 == 0);
      default: return 1'($urandom % 2);
    endcase
  endfunction

  initial begin
    int ya, yb, e, row, col;
    rst_n = 1'b0;
    lt_valid = 1'b0; rt_valid = 1'b0;
    lt_red = '0; lt_grn = '0; lt_blu = '0;
    rt_red = '0; rt_grn = '0; rt_blu = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(en_valid == 1'b0, "R9 en_valid", en_valid, 0);
    chk(en_sol == 1'b0 && en_eof == 1'b0, "R9 markers", {en_sol, en_eof}, 0);
    chk(lt_ready == 1'b1, "R9 lt_ready", lt_ready, 1);
    chk(rt_ready == 1'b1, "R9 rt_ready", rt_ready, 1);
    rst_n = 1'b1;
    lrdy_p = lt_ready; rrdy_p = rt_ready;
    while (out_n < N) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "R6 watchdog", out_n, N);
        break;
      end
      if (lt_valid && lrdy_p) begin
        lq.push_back(luma(lt_red, lt_grn, lt_blu)); lk++; lt_valid = 1'b0;
      end
      if (rt_valid && rrdy_p) begin
        rq.push_back(luma(rt_red, rt_grn, rt_blu)); rk++; rt_valid = 1'b0;
      end
      if (en_valid) begin
        if (lq.size() == 0 || rq.size() == 0) begin
          chk(1'b0, "R6 energy without input", out_n, -1);
        end else begin
          ya = lq.pop_front(); yb = rq.pop_front();
          e = (ya >= yb) ? ya - yb : yb - ya;
          row = (out_n / W) % H; col = out_n % W;
          if (yb == 0 || ya == 0) chk(en_value == e, "R1 luma extreme", en_value, e);
          else chk(en_value == e, "R2 abs diff", en_value, e);
          chk(en_col == col, "R3 column", en_col, col);
          chk(en_row == row, "R3 row", en_row, row);
          chk(en_sol == (col == 0), "R4 row start", en_sol, col == 0);
          chk(en_eof == (col == W - 1 && row == H - 1), "R5 frame end", en_eof, col == W - 1 && row == H - 1);
          if (col == 0)
            chk((lk / W > out_n / W) && (rk / W > out_n / W), "R6 both rows", lk / W * 100 + rk / W, out_n / W);
          out_n++;
        end
      end else begin
        chk(en_sol == 1'b0 && en_eof == 1'b0, "R4 idle markers", {en_sol, en_eof}, 0);
      end
      chk(lt_ready == ((lk / W - out_n / W) < 2), "R7 lt_ready", lt_ready, (lk / W - out_n / W) < 2);
      chk(rt_ready == ((rk / W - out_n / W) < 2), "R7 rt_ready", rt_ready, (rk / W - out_n / W) < 2);
      if (!lt_valid && lk < N && want(0, lk)) begin
        pick(0, lk, lt_red, lt_grn, lt_blu); lt_valid = 1'b1;
      end
      if (!rt_valid && rk < N && want(1, rk)) begin
        pick(1, rk, rt_red, rt_grn, rt_blu); rt_valid = 1'b1;
      end
      lrdy_p = lt_ready; rrdy_p = rt_ready;
    end
    repeat (4) @(negedge clk);
    chk(en_valid == 1'b0, "R8 no extra beat", en_valid, 0);
    chk(lk == N && rk == N, "R8 pixel count", lk + rk, 2 * N);
    chk(lq.size() == 0 && rq.size() == 0, "R8 leftover", lq.size() + rq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule